// File: doc/BRIEF.md
# Forced Cache Write-Back Scheduler

This block keeps a two-bit aging tag for every line of a data cache, in storage kept apart from the cache's own state. A scan pointer visits one line per clock cycle and wraps at the end of the array. A dirty line ages the first time the scan finds it. If it is still dirty when the scan comes round again, the block raises a write-back request for it. Stores to a line that is already dirty do not cause further memory traffic. They merge into the line until its forced write-back, so a dirty line always reaches non-volatile memory within a bounded number of passes, and no flush instructions are needed.

The cache reports three events to the block: each store, with its line index; each eviction; and each acknowledgment from memory that a write-back has finished. The block answers on a valid/ready request port, which carries the index of the line to write back. A probe port returns the tag of any chosen line, so the cache or a debugger can observe the tag state.

Top module: `fwb_sched`

## Requirements
- R1: After a synchronous active-low reset every tag reads clean (code 00), the scan index is 0 and no write-back request is raised.
- R2: A store to a clean line moves its tag to dirty-fresh (code 01) on the next cycle.
- R3: The scan index advances by one per cycle and wraps from NUM_LINES-1 to 0, except in a cycle when a request is raised and not accepted.
- R4: When the scan visits a dirty-fresh line, that line becomes dirty-aged (code 10).
- R5: When the scan index rests on a dirty-aged line, `wb_req_valid` is high and `wb_req_line` equals that index. Both hold steady, and the scan stays on that line, until `wb_req_ready` is seen.
- R6: An accepted request moves the line to write-back-pending (code 11). An acknowledgment for a pending line returns it to clean. An acknowledgment for a line that is not pending has no effect.
- R7: A store to a dirty-fresh or dirty-aged line leaves its tag unchanged (the store merges) and raises no extra request.
- R8: A store to a write-back-pending line sets it to dirty-fresh. The acknowledgment that arrives later leaves it dirty-fresh.
- R9: An eviction clears the line's tag to clean on the next cycle, overriding every other event. Evicting a line whose request is waiting withdraws that request.
- R10: While `wb_req_ready` stays high, a line written once from clean is requested within 2*NUM_LINES cycles.
- R11: A store to a line in the same cycle its request is accepted leaves the line dirty-fresh, not pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | A store hits a cache line this cycle |
| st_line | input | IDX_W | Line index of the store |
| ev_valid | input | 1 | A line is evicted this cycle |
| ev_line | input | IDX_W | Line index of the eviction |
| wb_ack_valid | input | 1 | Memory acknowledges a finished write-back |
| wb_ack_line | input | IDX_W | Line index of the acknowledgment |
| wb_req_valid | output | 1 | Forced write-back request |
| wb_req_ready | input | 1 | Request accepted this cycle |
| wb_req_line | output | IDX_W | Line to write back |
| scan_line | output | IDX_W | Current scan index |
| probe_line | input | IDX_W | Line whose tag is read out |
| probe_state | output | 2 | Tag of the probed line (00 clean, 01 fresh, 10 aged, 11 pending) |

## Verification
The bench drives single stores to clean lines and checks the aging steps, and the request that follows, as the scan passes. This separates a correct two-pass bound from a scan that ages too early or never fires. Repeated stores to fresh, aged and pending lines show whether merging is kept apart from re-dirtying after a write-back has started. Stalled and withdrawn requests, stray acknowledgments and a store made in the cycle of acceptance test the event-priority corners. Throughout, a scoreboard matches each accepted request against the line index the reference model predicts.

// File: rtl/fwb_pkg.sv
// Shared tag encoding for the forced write-back scheduler.
// Assumes: the codes are visible on the probe port and must not be reordered.
package fwb_pkg;
    typedef enum logic [1:0] {
        LN_CLEAN  = 2'b00,
        LN_FRESH  = 2'b01,
        LN_AGED   = 2'b10,
        LN_WBPEND = 2'b11
    } line_state_e;
endpackage

// File: rtl/fwb_line_tag.sv
// One line's aging tag and its next-state rules.
// Assumes: at most one store, one eviction and one acknowledgment per cycle,
// each carrying a line index; req_ready is only meaningful when the scan
// rests on this line while it is aged.
module fwb_line_tag
    import fwb_pkg::*;
#(
    parameter int IDX_W   = 4,
    parameter int LINE_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic [IDX_W-1:0] st_line,
    input  logic             ev_valid,
    input  logic [IDX_W-1:0] ev_line,
    input  logic             ack_valid,
    input  logic [IDX_W-1:0] ack_line,
    input  logic [IDX_W-1:0] scan_line,
    input  logic             req_ready,
    output line_state_e      state_o
);
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(LINE_ID);

    line_state_e state_q;
    line_state_e state_d;
    logic        st_hit;
    logic        ev_hit;
    logic        ack_hit;
    logic        scan_here;

    assign st_hit    = st_valid  && (st_line  == MY_IDX);
    assign ev_hit    = ev_valid  && (ev_line  == MY_IDX);
    assign ack_hit   = ack_valid && (ack_line == MY_IDX);
    assign scan_here = (scan_line == MY_IDX);

    // Tag next state: eviction first, then the per-state rules.
    always_comb begin
        state_d = state_q;
        if (ev_hit) begin
            state_d = LN_CLEAN;
        end else begin
            unique case (state_q)
                LN_CLEAN:  if (st_hit) state_d = LN_FRESH;
                LN_FRESH:  if (scan_here) state_d = LN_AGED;
                LN_AGED:   if (scan_here && req_ready)
                               state_d = st_hit ? LN_FRESH : LN_WBPEND;
                LN_WBPEND: if (st_hit) state_d = LN_FRESH;
                           else if (ack_hit) state_d = LN_CLEAN;
                default:   state_d = LN_CLEAN;
            endcase
        end
    end

    // Tag register with synchronous reset to clean.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LN_CLEAN;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // R2
    clean_to_fresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_CLEAN && st_hit && !ev_hit) |=> (state_q == LN_FRESH));
    // R4
    fresh_ages_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_FRESH && scan_here && !ev_hit) |=> (state_q == LN_AGED));
    // R6
    ack_cleans_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_WBPEND && ack_hit && !st_hit && !ev_hit) |=> (state_q == LN_CLEAN));
    // R7
    aged_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_AGED && st_hit && !ev_hit && !scan_here) |=> (state_q == LN_AGED));
    // R8
    pend_redirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LN_WBPEND && st_hit && !ev_hit) |=> (state_q == LN_FRESH));
    // R9
    evict_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_hit |=> (state_q == LN_CLEAN));
endmodule

// File: rtl/fwb_scan_ptr.sv
// Round-robin scan index: steps one line per cycle and wraps to zero.
// Assumes: hold_i is high only while a raised request waits for acceptance.
module fwb_scan_ptr #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    output logic [IDX_W-1:0] ptr_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    logic [IDX_W-1:0] ptr_q;

    // Advance or wrap unless the current request stalls the scan.
    always_ff @(posedge clk) begin
        if (!rst_n)              ptr_q <= '0;
        else if (hold_i)         ptr_q <= ptr_q;
        else if (ptr_q == LAST_IDX) ptr_q <= '0;
        else                     ptr_q <= ptr_q + 1'b1;
    end

    assign ptr_o = ptr_q;

    // R3
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_i |=> (ptr_q == (($past(ptr_q) == LAST_IDX) ? '0 : $past(ptr_q) + 1'b1)));
    // R3
    scan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(ptr_q));
endmodule

// File: rtl/fwb_state_pick.sv
// Selects one line's two-bit tag out of the flattened tag array.
// Assumes: an index at or beyond NUM_LINES reads as clean.
module fwb_state_pick #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4
) (
    input  logic [2*NUM_LINES-1:0] flat_i,
    input  logic [IDX_W-1:0]       sel_i,
    output logic [1:0]             state_o
);
    // Compare-and-select over all lines, no out-of-range part-select.
    always_comb begin
        state_o = 2'b00;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (sel_i == IDX_W'(k)) state_o = flat_i[2*k +: 2];
        end
    end
endmodule

// File: rtl/fwb_sched.sv
// Forced write-back scheduler top: per-line aging tags, a one-line-per-cycle
// scan, and a valid/ready request port for lines that must be written back.
// Assumes: the cache reports every store, eviction and write-back
// acknowledgment by line index; the data path lives outside this block.
module fwb_sched
    import fwb_pkg::*;
#(
    parameter int NUM_LINES = 64,
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic [IDX_W-1:0] st_line,
    input  logic             ev_valid,
    input  logic [IDX_W-1:0] ev_line,
    input  logic             wb_ack_valid,
    input  logic [IDX_W-1:0] wb_ack_line,
    output logic             wb_req_valid,
    input  logic             wb_req_ready,
    output logic [IDX_W-1:0] wb_req_line,
    output logic [IDX_W-1:0] scan_line,
    input  logic [IDX_W-1:0] probe_line,
    output logic [1:0]       probe_state
);
    line_state_e            line_state [NUM_LINES];
    logic [2*NUM_LINES-1:0] state_flat;
    logic [1:0]             scan_state;
    logic                   scan_hold;

    // One tag per cache line, each decoding its own events.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        fwb_line_tag #(
            .IDX_W   (IDX_W),
            .LINE_ID (g)
        ) u_tag (
            .clk       (clk),
            .rst_n     (rst_n),
            .st_valid  (st_valid),
            .st_line   (st_line),
            .ev_valid  (ev_valid),
            .ev_line   (ev_line),
            .ack_valid (wb_ack_valid),
            .ack_line  (wb_ack_line),
            .scan_line (scan_line),
            .req_ready (wb_req_ready),
            .state_o   (line_state[g])
        );
        assign state_flat[2*g +: 2] = line_state[g];
    end

    fwb_scan_ptr #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .hold_i (scan_hold),
        .ptr_o  (scan_line)
    );

    fwb_state_pick #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_pick_scan (
        .flat_i  (state_flat),
        .sel_i   (scan_line),
        .state_o (scan_state)
    );

    fwb_state_pick #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_pick_probe (
        .flat_i  (state_flat),
        .sel_i   (probe_line),
        .state_o (probe_state)
    );

    // Request whenever the scan rests on an aged line; stall until accepted.
    always_comb begin
        wb_req_valid = (scan_state == LN_AGED);
        wb_req_line  = scan_line;
        scan_hold    = wb_req_valid && !wb_req_ready;
    end

    // R5
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_valid && !wb_req_ready && !(ev_valid && ev_line == wb_req_line))
        |=> (wb_req_valid && $stable(wb_req_line)));
    // R9
    req_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req_valid && !wb_req_ready && ev_valid && ev_line == wb_req_line)
        |=> !wb_req_valid);
endmodule

// File: tb/fwb_sched_tb_top.sv
module fwb_sched_tb_top;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam logic [1:0] S_CLEAN = 2'b00;
    localparam logic [1:0] S_FRESH = 2'b01;
    localparam logic [1:0] S_AGED  = 2'b10;
    localparam logic [1:0] S_PEND  = 2'b11;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          st_valid, ev_valid, wb_ack_valid, wb_req_ready;
    logic [IW-1:0] st_line, ev_line, wb_ack_line, probe_line;
    logic          wb_req_valid;
    logic [IW-1:0] wb_req_line, scan_line;
    logic [1:0]    probe_state;

    fwb_sched #(.NUM_LINES(N)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_line(st_line),
        .ev_valid(ev_valid), .ev_line(ev_line),
        .wb_ack_valid(wb_ack_valid), .wb_ack_line(wb_ack_line),
        .wb_req_valid(wb_req_valid), .wb_req_ready(wb_req_ready),
        .wb_req_line(wb_req_line), .scan_line(scan_line),
        .probe_line(probe_line), .probe_state(probe_state)
    );

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    bit done = 0;

    logic [1:0] mtag [N];
    int mptr;

    logic          d_st = 0, d_ev = 0, d_ak = 0, d_rdy = 1;
    logic [IW-1:0] d_sidx = '0, d_eidx = '0, d_aidx = '0, pidx = '0;
    int obs_scan, obs_valid, obs_idx, obs_probe;

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference model: tag rules and scan stepping taken from the requirements.
    task automatic model_step();
        logic [1:0] nt [N];
        bit req;
        req = (mtag[mptr] == S_AGED);
        for (int i = 0; i < N; i++) begin
            nt[i] = mtag[i];
            if (d_ev && int'(d_eidx) == i) nt[i] = S_CLEAN;
            else if (mtag[i] == S_CLEAN) begin
                if (d_st && int'(d_sidx) == i) nt[i] = S_FRESH;
            end else if (mtag[i] == S_FRESH) begin
                if (mptr == i) nt[i] = S_AGED;
            end else if (mtag[i] == S_AGED) begin
                if (mptr == i && d_rdy) nt[i] = (d_st && int'(d_sidx) == i) ? S_FRESH : S_PEND;
            end else begin
                if (d_st && int'(d_sidx) == i) nt[i] = S_FRESH;
                else if (d_ak && int'(d_aidx) == i) nt[i] = S_CLEAN;
            end
        end
        for (int i = 0; i < N; i++) mtag[i] = nt[i];
        if (!(req && !d_rdy)) mptr = (mptr == N - 1) ? 0 : mptr + 1;
    endtask

    // Driver: one clock of stimulus, observation, model compare and scoreboard push.
    task automatic cycle();
        int ev;
        @(negedge clk);
        st_valid = d_st; st_line = d_sidx;
        ev_valid = d_ev; ev_line = d_eidx;
        wb_ack_valid = d_ak; wb_ack_line = d_aidx;
        wb_req_ready = d_rdy; probe_line = pidx;
        #1;
        obs_scan = int'(scan_line); obs_valid = int'(wb_req_valid);
        obs_idx = int'(wb_req_line); obs_probe = int'(probe_state);
        check_eq("R3 scan position", obs_scan, mptr);
        ev = (mtag[mptr] == S_AGED) ? 1 : 0;
        check_eq("R5 request valid", obs_valid, ev);
        if (ev == 1) check_eq("R5 request line", obs_idx, mptr);
        check_eq("R4 probed tag", obs_probe, int'(mtag[int'(pidx)]));
        if (ev == 1 && d_rdy) exp_q.push_back(mptr);
        model_step();
        d_st = 0; d_ev = 0; d_ak = 0;
    endtask

    task automatic wait_scan(input int target);
        int n = 0;
        do begin
            cycle();
            n++;
        end while (obs_scan != target && n < 4 * N);
    endtask

    // Monitor: pops expected write-back lines as handshakes occur.
    always @(negedge clk) begin
        int e;
        #2;
        if (rst_n && wb_req_valid && wb_req_ready) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R5 unexpected write-back: actual %0d expected none", wb_req_line);
            end else begin
                e = exp_q.pop_front();
                check_eq("R5 accepted write-back line", int'(wb_req_line), e);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst_n = 0;
        st_valid = 0; ev_valid = 0; wb_ack_valid = 0; wb_req_ready = 1;
        st_line = '0; ev_line = '0; wb_ack_line = '0; probe_line = '0;
        for (int i = 0; i < N; i++) mtag[i] = S_CLEAN;
        mptr = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        pidx = 0; cycle();
        check_eq("R1 scan index", obs_scan, 0);
        check_eq("R1 no request", obs_valid, 0);
        check_eq("R1 line 0 clean", obs_probe, 0);
        for (int i = 1; i < N; i++) begin
            pidx = IW'(i); cycle();
            check_eq("R1 line clean", obs_probe, 0);
        end

        // R2: store to clean line
        wait_scan(0);
        d_st = 1; d_sidx = 5; cycle();
        pidx = 5; cycle();
        check_eq("R2 fresh after store", obs_probe, 1);

        // R4: scan ages fresh line
        wait_scan(5);
        d_rdy = 0; cycle();
        check_eq("R4 aged after scan", obs_probe, 2);

        // R7: merge into aged line
        d_st = 1; d_sidx = 5; cycle(); cycle();
        check_eq("R7 aged kept", obs_probe, 2);
        check_eq("R7 no extra request", obs_valid, 0);

        // R5: request and stall
        wait_scan(5);
        check_eq("R5 valid on aged", obs_valid, 1);
        check_eq("R5 line on aged", obs_idx, 5);
        repeat (3) cycle();
        check_eq("R5 scan stalled", obs_scan, 5);
        check_eq("R5 request held", obs_valid, 1);

        // R6: accept then pending; stray ack ignored
        d_rdy = 1; cycle(); cycle();
        check_eq("R6 pending after accept", obs_probe, 3);
        check_eq("R3 resumes after accept", obs_scan, 6);
        d_ak = 1; d_aidx = 2; cycle();
        pidx = 2; cycle();
        check_eq("R6 stray ack ignored", obs_probe, 0);

        // R8: store to pending, later ack ignored
        pidx = 5; d_st = 1; d_sidx = 5; cycle(); cycle();
        check_eq("R8 refreshed from pending", obs_probe, 1);
        d_ak = 1; d_aidx = 5; cycle(); cycle();
        check_eq("R8 ack after refresh ignored", obs_probe, 1);
        repeat (2 * N + 2) cycle();
        check_eq("R6 pending again", obs_probe, 3);
        d_ak = 1; d_aidx = 5; cycle(); cycle();
        check_eq("R6 ack cleans", obs_probe, 0);

        // R9: eviction clears; eviction withdraws waiting request
        pidx = 1; d_st = 1; d_sidx = 1; cycle();
        d_ev = 1; d_eidx = 1; cycle(); cycle();
        check_eq("R9 evicted line clean", obs_probe, 0);
        d_st = 1; d_sidx = 3; cycle();
        d_rdy = 0; wait_scan(3); wait_scan(3);
        check_eq("R5 waiting request", obs_valid, 1);
        d_ev = 1; d_eidx = 3; cycle();
        pidx = 3; cycle();
        check_eq("R9 request withdrawn", obs_valid, 0);
        check_eq("R9 withdrawn line clean", obs_probe, 0);

        // R11: store during acceptance
        d_rdy = 1; d_st = 1; d_sidx = 4; cycle();
        d_rdy = 0; wait_scan(4); wait_scan(4);
        d_rdy = 1; d_st = 1; d_sidx = 4; cycle();
        pidx = 4; cycle();
        check_eq("R11 fresh after accept with store", obs_probe, 1);

        // R10: persistence bound
        repeat (2 * N + 2) cycle();
        d_st = 1; d_sidx = 7; cycle();
        cnt = 0;
        do begin
            cycle();
            cnt++;
        end while (!(obs_valid == 1 && obs_idx == 7) && cnt < 4 * N);
        check_eq("R10 request within bound", (cnt <= 2 * N) ? 1 : 0, 1);

        // R3: wrap
        wait_scan(N - 1); cycle();
        check_eq("R3 wrap to zero", obs_scan, 0);

        repeat (4) cycle();
        check_eq("R5 scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule